// File: doc/BRIEF.md
# Cascaded Two-Group Interrupt Controller

This block collects interrupt requests into two local groups and drives one interrupt line per group. Each group keeps seven hardware-set source bits and a software mask. A third status byte gathers secondary sources; two separate routing masks each select a subset of that shared byte. Whenever a group's selected subset has any bit set, bit 7 of that group's status reads as one. A secondary source can therefore reach group 0, group 1, both, or neither.

Sources set and clear status bits through per-bit pulse inputs. Software uses a single-cycle register port to read status, program the masks, keep an 8-bit polarity value, and fire a timer-clear strobe. The polarity value is stored and read back only. It has no effect on any interrupt path.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: After reset, every register reads zero, and `irq0`, `irq1` and `tclr_strobe` are low.
- R2: A one on bit i of `l0_set`/`l1_set` sets status bit i (0 to 6) of that group at the next clock edge. A one on the matching `*_clr` bit clears it. When both are high in the same cycle, set wins.
- R3: Group 0 status bit 7 reads one exactly when (routing mask 0 AND secondary status) is nonzero.
- R4: Group 1 status bit 7 reads one exactly when (routing mask 1 AND secondary status) is nonzero.
- R5: A write to a routing mask updates the matching bit 7 by the next edge, with no change needed on any source. The same holds when a secondary source is raised or lowered.
- R6: `irqN` is high exactly when (group N status including bit 7) AND (group N mask) is nonzero.
- R7: `map_set`/`map_clr` set and clear the 8-bit secondary status in the same way as R2, with set winning.
- R8: The polarity register (offset 7) reads back the last value written to it and has no effect on `irq0`/`irq1`.
- R9: A write to offset 8 raises `tclr_strobe` for exactly one cycle, starting at the edge after the write. A read of offset 8 returns zero.
- R10: Register offsets are: 0 group 0 status, 1 group 0 mask, 2 group 1 status, 3 group 1 mask, 4 secondary status, 5 routing mask 0, 6 routing mask 1, 7 polarity, 8 timer clear. Reads of offsets 9 to 15 return zero. Writes to the status offsets (0, 2, 4) change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l0_set | input | 7 | Group 0 source set pulses, bits 0..6 |
| l0_clr | input | 7 | Group 0 source clear pulses |
| l1_set | input | 7 | Group 1 source set pulses |
| l1_clr | input | 7 | Group 1 source clear pulses |
| map_set | input | 8 | Secondary source set pulses |
| map_clr | input | 8 | Secondary source clear pulses |
| reg_wen | input | 1 | Register write enable |
| reg_addr | input | AW | Register word offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from `reg_addr`) |
| irq0 | output | 1 | Group 0 interrupt line |
| irq1 | output | 1 | Group 1 interrupt line |
| tclr_strobe | output | 1 | One-cycle timer-clear pulse |

## Verification
A stale routing evaluation would show up as a wrong bit 7 on a status read, and as a wrong `irq` level, one cycle after a mask write or a secondary source change. The bench reads those points right after each change. A mixed-up routing mask would drive the wrong group, so the directed tests route a single secondary source into group 1 only and then into neither group. A register stuck in a wrong state shows on its read-back, or on an interrupt line that stays high or low after its status and mask have been set up to decide it.

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [6:0]    l0_set,
  input  logic [6:0]    l0_clr,
  input  logic [6:0]    l1_set,
  input  logic [6:0]    l1_clr,
  input  logic [7:0]    map_set,
  input  logic [7:0]    map_clr,
  input  logic          reg_wen,
  input  logic [AW-1:0] reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          irq0,
  output logic          irq1,
  output logic          tclr_strobe
);

  localparam logic [AW-1:0] OFF_L0_STAT = AW'(0);
  localparam logic [AW-1:0] OFF_L0_MASK = AW'(1);
  localparam logic [AW-1:0] OFF_L1_STAT = AW'(2);
  localparam logic [AW-1:0] OFF_L1_MASK = AW'(3);
  localparam logic [AW-1:0] OFF_MAP_STAT = AW'(4);
  localparam logic [AW-1:0] OFF_MAP_M0 = AW'(5);
  localparam logic [AW-1:0] OFF_MAP_M1 = AW'(6);
  localparam logic [AW-1:0] OFF_POL = AW'(7);
  localparam logic [AW-1:0] OFF_TCLR = AW'(8);

  logic [6:0] src0_q, src1_q;
  logic [7:0] lmask0_q, lmask1_q;
  logic [7:0] map_q, route0_q, route1_q, pol_q;
  logic       tclr_q;
  logic       sum0, sum1;
  logic [7:0] stat0, stat1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src0_q <= '0;
      src1_q <= '0;
      map_q  <= '0;
    end else begin
      src0_q <= (src0_q & ~l0_clr) | l0_set;
      src1_q <= (src1_q & ~l1_clr) | l1_set;
      map_q  <= (map_q & ~map_clr) | map_set;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lmask0_q <= '0;
      lmask1_q <= '0;
      route0_q <= '0;
      route1_q <= '0;
      pol_q    <= '0;
      tclr_q   <= 1'b0;
    end else begin
      tclr_q <= reg_wen && (reg_addr == OFF_TCLR);
      if (reg_wen) begin
        case (reg_addr)
          OFF_L0_MASK: lmask0_q <= reg_wdata;
          OFF_L1_MASK: lmask1_q <= reg_wdata;
          OFF_MAP_M0:  route0_q <= reg_wdata;
          OFF_MAP_M1:  route1_q <= reg_wdata;
          OFF_POL:     pol_q    <= reg_wdata;
          default: ;
        endcase
      end
    end
  end

  assign sum0  = |(route0_q & map_q);
  assign sum1  = |(route1_q & map_q);
  assign stat0 = {sum0, src0_q};
  assign stat1 = {sum1, src1_q};

  assign irq0        = |(stat0 & lmask0_q);
  assign irq1        = |(stat1 & lmask1_q);
  assign tclr_strobe = tclr_q;

  always_comb begin
    case (reg_addr)
      OFF_L0_STAT:  reg_rdata = stat0;
      OFF_L0_MASK:  reg_rdata = lmask0_q;
      OFF_L1_STAT:  reg_rdata = stat1;
      OFF_L1_MASK:  reg_rdata = lmask1_q;
      OFF_MAP_STAT: reg_rdata = map_q;
      OFF_MAP_M0:   reg_rdata = route0_q;
      OFF_MAP_M1:   reg_rdata = route1_q;
      OFF_POL:      reg_rdata = pol_q;
      default:      reg_rdata = 8'h00;
    endcase
  end

  // R2
  l0_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((src0_q & $past(l0_set)) == $past(l0_set)));

  // R7
  map_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((map_q & ($past(map_clr) & ~$past(map_set))) == 8'h00));

  // R5
  route0_reeval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wen && reg_addr == OFF_MAP_M0 && map_set == 8'h00 && map_clr == 8'h00)
    |=> (stat0[7] == |($past(reg_wdata) & $past(map_q))));

  // R5
  route1_reeval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wen && reg_addr == OFF_MAP_M1 && map_set == 8'h00 && map_clr == 8'h00)
    |=> (stat1[7] == |($past(reg_wdata) & $past(map_q))));

  // R8
  pol_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wen && reg_addr == OFF_POL) |=> $stable(pol_q));

  // R9
  tclr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tclr_strobe |=> !tclr_strobe || $past(reg_wen && reg_addr == OFF_TCLR));

  // R9
  tclr_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == OFF_TCLR) |-> (reg_rdata == 8'h00));

endmodule

// File: tb/cascade_irq_ctrl_tb.sv
module cascade_irq_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] l0_set = '0, l0_clr = '0, l1_set = '0, l1_clr = '0;
  logic [7:0] map_set = '0, map_clr = '0;
  logic       reg_wen = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq0, irq1, tclr_strobe;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cascade_irq_ctrl #(.AW(4)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .l0_set(l0_set), .l0_clr(l0_clr), .l1_set(l1_set), .l1_clr(l1_clr),
    .map_set(map_set), .map_clr(map_clr),
    .reg_wen(reg_wen), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq0(irq0), .irq1(irq1), .tclr_strobe(tclr_strobe)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic src(input logic [6:0] s0, input logic [6:0] c0,
                     input logic [6:0] s1, input logic [6:0] c1,
                     input logic [7:0] ms, input logic [7:0] mc);
    @(negedge clk);
    l0_set = s0; l0_clr = c0; l1_set = s1; l1_clr = c1; map_set = ms; map_clr = mc;
    @(negedge clk);
    l0_set = '0; l0_clr = '0; l1_set = '0; l1_clr = '0; map_set = '0; map_clr = '0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    for (int a = 0; a < 9; a++) begin
      rd(4'(a), v);
      chk("R1 reg after reset", v, 8'h00);
    end
    chk("R1 irq0", {7'd0, irq0}, 8'h00);
    chk("R1 irq1", {7'd0, irq1}, 8'h00);
    chk("R1 tclr", {7'd0, tclr_strobe}, 8'h00);
  endtask

  task automatic t_local;
    logic [7:0] v;
    src(7'h03, 0, 0, 0, 0, 0);
    rd(0, v); chk("R2 l0 set", v, 8'h03);
    src(0, 7'h01, 0, 0, 0, 0);
    rd(0, v); chk("R2 l0 clear", v, 8'h02);
    src(7'h04, 7'h04, 0, 0, 0, 0);
    rd(0, v); chk("R2 set wins", v, 8'h06);
    src(0, 0, 7'h02, 0, 0, 0);
    rd(2, v); chk("R2 l1 set", v, 8'h02);
    chk("R6 masked off", {7'd0, irq0}, 8'h00);
    wr(1, 8'h04);
    rd(1, v); chk("R10 mask0 readback", v, 8'h04);
    chk("R6 irq0 on", {7'd0, irq0}, 8'h01);
    wr(1, 8'h01);
    chk("R6 irq0 off", {7'd0, irq0}, 8'h00);
    wr(3, 8'h02);
    chk("R6 irq1 on", {7'd0, irq1}, 8'h01);
    src(0, 7'h7f, 0, 7'h7f, 0, 0);
    rd(0, v); chk("R2 l0 cleared", v, 8'h00);
    rd(2, v); chk("R2 l1 cleared", v, 8'h00);
    chk("R6 irq1 off", {7'd0, irq1}, 8'h00);
  endtask

  task automatic t_cascade;
    logic [7:0] v;
    src(0, 0, 0, 0, 8'h10, 0);
    rd(4, v); chk("R7 map set", v, 8'h10);
    rd(0, v); chk("R3 unrouted", v, 8'h00);
    wr(5, 8'h10);
    rd(0, v); chk("R5 route0 write reeval", v, 8'h80);
    rd(2, v); chk("R4 group1 untouched", v, 8'h00);
    wr(1, 8'h80);
    chk("R6 irq0 via cascade", {7'd0, irq0}, 8'h01);
    wr(6, 8'h30);
    rd(2, v); chk("R5 route1 write reeval", v, 8'h80);
    wr(3, 8'h80);
    chk("R6 irq1 via cascade", {7'd0, irq1}, 8'h01);
    src(0, 0, 0, 0, 0, 8'h10);
    rd(0, v); chk("R3 source drop", v, 8'h00);
    rd(2, v); chk("R4 source drop", v, 8'h00);
    chk("R6 irq0 drop", {7'd0, irq0}, 8'h00);
    src(0, 0, 0, 0, 8'h20, 8'h20);
    rd(4, v); chk("R7 set wins", v, 8'h20);
    rd(0, v); chk("R3 other bit not routed", v, 8'h00);
    rd(2, v); chk("R4 group1 only", v, 8'h80);
    chk("R6 irq1 group1 only", {7'd0, irq1}, 8'h01);
    wr(6, 8'h00);
    rd(2, v); chk("R5 route1 cleared", v, 8'h00);
    chk("R6 irq1 after unroute", {7'd0, irq1}, 8'h00);
  endtask

  task automatic t_pol;
    logic [7:0] v;
    wr(7, 8'hA5);
    rd(7, v); chk("R8 polarity readback", v, 8'hA5);
    chk("R8 irq0 unaffected", {7'd0, irq0}, 8'h00);
    chk("R8 irq1 unaffected", {7'd0, irq1}, 8'h00);
  endtask

  task automatic t_tclr;
    logic [7:0] v;
    chk("R9 idle", {7'd0, tclr_strobe}, 8'h00);
    wr(8, 8'h5A);
    chk("R9 strobe high", {7'd0, tclr_strobe}, 8'h01);
    @(negedge clk);
    chk("R9 strobe one cycle", {7'd0, tclr_strobe}, 8'h00);
    rd(8, v); chk("R9 read zero", v, 8'h00);
  endtask

  task automatic t_map;
    logic [7:0] v;
    rd(9, v);  chk("R10 unmapped 9", v, 8'h00);
    rd(15, v); chk("R10 unmapped 15", v, 8'h00);
    wr(0, 8'hFF);
    rd(0, v); chk("R10 status0 write ignored", v, 8'h00);
    wr(4, 8'hFF);
    rd(4, v); chk("R10 map status write ignored", v, 8'h20);
    wr(2, 8'hFF);
    rd(2, v); chk("R10 status1 write ignored", v, 8'h00);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_local();
    t_cascade();
    t_pol();
    t_tclr();
    t_map();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule